// File: doc/BRIEF.md
# Jacobian Point Doubling Sequencer

This block doubles a point on a short Weierstrass curve whose linear coefficient is −3. The point arrives in Jacobian projective coordinates over a small prime field, and the result leaves in the same form. A one-cycle `start` pulse captures the input point. An internal micro-program then runs a fixed list of field operations over a small register file. That list uses copy, modular add, modular subtract and a bit-serial modular multiply. `done` pulses once when the result is available on the outputs.

The multiplier latches both operands from two read ports of the register file. The program never names the same register on both ports. To square a value, it first copies the value into a scratch register and then multiplies the original by the copy. The factor three is built from two additions. Division by two is a multiplication by a parameter that holds the inverse of two modulo the field prime. An input with zero Z is flagged at capture. The whole program still runs for such an input, and the output is then forced to the point at infinity. Run time therefore does not depend on the data.

Top module: `jdbl_core`

## Requirements
- R1: After reset, `busy` and `done` are low and `rx`, `ry`, `rz` are all zero.
- R2: While idle, a high `start` captures `px`, `py`, `pz` and raises `busy` in the next cycle. `done` is high for exactly one cycle, `busy` is already low in that cycle, and the outputs are valid from that cycle until the next result.
- R3: For an input with Y and Z nonzero, the result converted to affine form (`rx`/`rz`², `ry`/`rz`³ mod Q) equals the affine double of (X/Z², Y/Z³). The affine double uses slope (3x² − 3)/(2y), gives x' = slope² − 2x and y' = slope·(x − x') − y.
- R4: `rz` equals 2·Y·Z mod Q for every input whose Z is nonzero.
- R5: All output coordinates lie in [0, Q) when the input coordinates do.
- R6: An input with Z = 0 produces exactly `rx` = 1, `ry` = 1, `rz` = 0, whatever X and Y are.
- R7: The number of cycles from `start` to `done` is the same for every input, including the point at infinity and points with Y = 0.
- R8: `start` is ignored while `busy` is high. The result reflects the point captured at the accepted `start`, and only one `done` pulse follows it.
- R9: A finite input with Y = 0 (a point of order two) produces `rz` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a doubling; sampled only when idle |
| px | input | W | Input X coordinate, below Q |
| py | input | W | Input Y coordinate, below Q |
| pz | input | W | Input Z coordinate, below Q; zero means infinity |
| busy | output | 1 | Micro-program in progress |
| done | output | 1 | One-cycle pulse: result valid |
| rx | output | W | Result X coordinate |
| ry | output | W | Result Y coordinate |
| rz | output | W | Result Z coordinate |

## Verification
The hardest case to reach from the ports is an input at infinity. For that input the program still computes a full set of meaningless intermediate values, and only the final override may decide the output. The bench drives Z = 0 with several non-trivial X and Y values, so that an override that is missing or partial shows up as a wrong coordinate. It also compares the cycle count of that run with the count of finite runs. Points of order two and a second `start` issued in the middle of a run are driven directly, so that the wrap-around in subtraction and the rule that ignores `start` while busy are both exercised.

// File: rtl/jdbl_pkg.sv
package jdbl_pkg;

  typedef enum logic [1:0] {
    OP_COPY = 2'd0,
    OP_ADD  = 2'd1,
    OP_SUB  = 2'd2,
    OP_MUL  = 2'd3
  } op_e;

  localparam int IDX_W    = 4;
  localparam int NSTORE   = 9;
  localparam int PROG_LEN = 23;
  localparam int PC_W     = $clog2(PROG_LEN);

  typedef logic [IDX_W-1:0] ridx_t;
  typedef logic [PC_W-1:0]  pc_t;

  // register file slots; K_HALF is a read-only constant slot
  localparam ridx_t K_X    = 4'd0;
  localparam ridx_t K_Y    = 4'd1;
  localparam ridx_t K_Z    = 4'd2;
  localparam ridx_t K_OX   = 4'd3;
  localparam ridx_t K_OY   = 4'd4;
  localparam ridx_t K_OZ   = 4'd5;
  localparam ridx_t K_S1   = 4'd6;
  localparam ridx_t K_S2   = 4'd7;
  localparam ridx_t K_S3   = 4'd8;
  localparam ridx_t K_HALF = 4'd9;

  typedef struct packed {
    op_e   op;
    ridx_t sa;
    ridx_t sb;
    ridx_t dst;
  } uop_t;

  localparam pc_t LAST_PC = pc_t'(PROG_LEN - 1);

  // micro-program: dst <= sa (op) sb ; copy uses sa only
  function automatic uop_t prog_rom(input pc_t pc);
    uop_t u;
    case (pc)
      5'd0:  u = '{OP_COPY, K_Z,  K_Z,    K_S1};
      5'd1:  u = '{OP_MUL,  K_Z,  K_S1,   K_S1};
      5'd2:  u = '{OP_SUB,  K_X,  K_S1,   K_S2};
      5'd3:  u = '{OP_ADD,  K_X,  K_S1,   K_S1};
      5'd4:  u = '{OP_MUL,  K_S1, K_S2,   K_S2};
      5'd5:  u = '{OP_ADD,  K_S2, K_S2,   K_S1};
      5'd6:  u = '{OP_ADD,  K_S1, K_S2,   K_S2};
      5'd7:  u = '{OP_ADD,  K_Y,  K_Y,    K_OY};
      5'd8:  u = '{OP_MUL,  K_Z,  K_OY,   K_OZ};
      5'd9:  u = '{OP_COPY, K_OY, K_OY,   K_S1};
      5'd10: u = '{OP_COPY, K_OY, K_OY,   K_S3};
      5'd11: u = '{OP_MUL,  K_S1, K_S3,   K_OY};
      5'd12: u = '{OP_MUL,  K_X,  K_OY,   K_S3};
      5'd13: u = '{OP_COPY, K_OY, K_OY,   K_S1};
      5'd14: u = '{OP_MUL,  K_OY, K_S1,   K_S1};
      5'd15: u = '{OP_MUL,  K_S1, K_HALF, K_OY};
      5'd16: u = '{OP_COPY, K_S2, K_S2,   K_S1};
      5'd17: u = '{OP_MUL,  K_S1, K_S2,   K_OX};
      5'd18: u = '{OP_ADD,  K_S3, K_S3,   K_S1};
      5'd19: u = '{OP_SUB,  K_OX, K_S1,   K_OX};
      5'd20: u = '{OP_SUB,  K_S3, K_OX,   K_S1};
      5'd21: u = '{OP_MUL,  K_S1, K_S2,   K_S1};
      5'd22: u = '{OP_SUB,  K_S1, K_OY,   K_OY};
      default: u = '{OP_COPY, K_S1, K_S1, K_S1};
    endcase
    return u;
  endfunction

endpackage

// File: rtl/jdbl_regfile.sv
module jdbl_regfile
  import jdbl_pkg::*;
#(
  parameter int              W    = 8,
  parameter logic [W-1:0]    HALF = 8'd126
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] in_x,
  input  logic [W-1:0] in_y,
  input  logic [W-1:0] in_z,
  input  logic         wr_en,
  input  ridx_t        wr_idx,
  input  logic [W-1:0] wr_data,
  input  ridx_t        rd_a_idx,
  input  ridx_t        rd_b_idx,
  output logic [W-1:0] rd_a,
  output logic [W-1:0] rd_b,
  output logic [W-1:0] res_x,
  output logic [W-1:0] res_y,
  output logic [W-1:0] res_z
);

  logic [W-1:0] regs [NSTORE];

  function automatic logic [W-1:0] load_val(input int slot,
                                            input logic [W-1:0] x,
                                            input logic [W-1:0] y,
                                            input logic [W-1:0] z);
    if (slot == int'(K_X)) return x;
    if (slot == int'(K_Y)) return y;
    if (slot == int'(K_Z)) return z;
    return '0;
  endfunction

  always_ff @(posedge clk) begin
    for (int i = 0; i < NSTORE; i++) begin
      if (!rst_n)
        regs[i] <= '0;
      else if (load)
        regs[i] <= load_val(i, in_x, in_y, in_z);
      else if (wr_en && (int'(wr_idx) == i))
        regs[i] <= wr_data;
    end
  end

  function automatic logic [W-1:0] rd(input ridx_t idx);
    logic [W-1:0] v;
    v = '0;
    if (idx == K_HALF)
      v = HALF;
    else
      for (int i = 0; i < NSTORE; i++)
        if (int'(idx) == i) v = regs[i];
    return v;
  endfunction

  assign rd_a  = rd(rd_a_idx);
  assign rd_b  = rd(rd_b_idx);
  assign res_x = regs[K_OX];
  assign res_y = regs[K_OY];
  assign res_z = regs[K_OZ];

endmodule

// File: rtl/jdbl_addsub.sv
module jdbl_addsub #(
  parameter int W = 8,
  parameter int Q = 251
) (
  input  logic         sub,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);

  localparam logic [W:0] QX = (W+1)'(Q);

  // single conditional correction keeps results in [0, Q)
  function automatic logic [W-1:0] f_add(input logic [W-1:0] x, input logic [W-1:0] z);
    logic [W:0] s;
    s = {1'b0, x} + {1'b0, z};
    if (s >= QX) s = s - QX;
    return s[W-1:0];
  endfunction

  function automatic logic [W-1:0] f_sub(input logic [W-1:0] x, input logic [W-1:0] z);
    logic [W:0] d;
    d = {1'b0, x} - {1'b0, z};
    if (x < z) d = d + QX;
    return d[W-1:0];
  endfunction

  assign y = sub ? f_sub(a, b) : f_add(a, b);

endmodule

// File: rtl/jdbl_modmul.sv
module jdbl_modmul #(
  parameter int W = 8,
  parameter int Q = 251
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         done,
  output logic [W-1:0] y
);

  localparam int         CW = $clog2(W + 1);
  localparam logic [W+1:0] QX = (W+2)'(Q);

  logic [W-1:0]  opa;
  logic [W-1:0]  opb;
  logic [W-1:0]  acc;
  logic [CW-1:0] cnt;
  logic          running;

  // one MSB-first step: acc = 2*acc + bit*opa, reduced mod Q
  function automatic logic [W-1:0] mstep(input logic [W-1:0] ac,
                                         input logic [W-1:0] x,
                                         input logic         bit_i);
    logic [W+1:0] t;
    t = {1'b0, ac, 1'b0};
    if (t >= QX) t = t - QX;
    if (bit_i) t = t + {2'b00, x};
    if (t >= QX) t = t - QX;
    return t[W-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      opa     <= '0;
      opb     <= '0;
      acc     <= '0;
      cnt     <= '0;
      running <= 1'b0;
      done    <= 1'b0;
    end else if (start) begin
      opa     <= a;
      opb     <= b;
      acc     <= '0;
      cnt     <= CW'(W);
      running <= 1'b1;
      done    <= 1'b0;
    end else if (running) begin
      acc <= mstep(acc, opa, opb[W-1]);
      opb <= opb << 1;
      cnt <= cnt - 1'b1;
      if (cnt == CW'(1)) begin
        running <= 1'b0;
        done    <= 1'b1;
      end
    end else begin
      done <= 1'b0;
    end
  end

  assign y = acc;

endmodule

// File: rtl/jdbl_core.sv
module jdbl_core
  import jdbl_pkg::*;
#(
  parameter int           W    = 8,
  parameter int           Q    = 251,
  parameter logic [W-1:0] HALF = W'((Q + 1) / 2)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] px,
  input  logic [W-1:0] py,
  input  logic [W-1:0] pz,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] rx,
  output logic [W-1:0] ry,
  output logic [W-1:0] rz
);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_MWAIT, S_FIN} st_e;

  st_e          state;
  pc_t          pc;
  uop_t         cur;
  logic         inf_q;
  logic         load;
  logic         wr_en;
  logic [W-1:0] wr_data;
  logic         mul_start;
  logic         mul_done;
  logic [W-1:0] mul_y;
  logic [W-1:0] rd_a, rd_b, as_y;
  logic [W-1:0] fx, fy, fz;
  ridx_t        mul_sel_a, mul_sel_b;
  logic         step_adv;

  assign cur       = prog_rom(pc);
  assign load      = (state == S_IDLE) && start;
  assign mul_sel_a = cur.sa;
  assign mul_sel_b = cur.sb;

  always_comb begin
    wr_en     = 1'b0;
    wr_data   = as_y;
    mul_start = 1'b0;
    step_adv  = 1'b0;
    if (state == S_RUN) begin
      if (cur.op == OP_MUL) begin
        mul_start = 1'b1;
      end else begin
        wr_en    = 1'b1;
        wr_data  = (cur.op == OP_COPY) ? rd_a : as_y;
        step_adv = 1'b1;
      end
    end else if (state == S_MWAIT && mul_done) begin
      wr_en    = 1'b1;
      wr_data  = mul_y;
      step_adv = 1'b1;
    end
  end

  jdbl_regfile #(.W(W), .HALF(HALF)) u_rf (
    .clk(clk), .rst_n(rst_n), .load(load),
    .in_x(px), .in_y(py), .in_z(pz),
    .wr_en(wr_en), .wr_idx(cur.dst), .wr_data(wr_data),
    .rd_a_idx(cur.sa), .rd_b_idx(cur.sb), .rd_a(rd_a), .rd_b(rd_b),
    .res_x(fx), .res_y(fy), .res_z(fz)
  );

  jdbl_addsub #(.W(W), .Q(Q)) u_as (
    .sub(cur.op == OP_SUB), .a(rd_a), .b(rd_b), .y(as_y)
  );

  jdbl_modmul #(.W(W), .Q(Q)) u_mul (
    .clk(clk), .rst_n(rst_n), .start(mul_start),
    .a(rd_a), .b(rd_b), .done(mul_done), .y(mul_y)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      pc    <= '0;
      inf_q <= 1'b0;
      done  <= 1'b0;
      rx    <= '0;
      ry    <= '0;
      rz    <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          inf_q <= (pz == '0);
          pc    <= '0;
          state <= S_RUN;
        end
        S_RUN, S_MWAIT: begin
          if (mul_start) state <= S_MWAIT;
          if (step_adv) begin
            if (pc == LAST_PC) state <= S_FIN;
            else begin
              pc    <= pc + 1'b1;
              state <= S_RUN;
            end
          end
        end
        S_FIN: begin
          rx    <= inf_q ? W'(1) : fx;
          ry    <= inf_q ? W'(1) : fy;
          rz    <= inf_q ? '0    : fz;
          done  <= 1'b1;
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy = (state != S_IDLE);

endmodule

// File: rtl/jdbl_core_chk.sv
module jdbl_core_chk
  import jdbl_pkg::*;
#(
  parameter int W = 8,
  parameter int Q = 251
) (
  input logic         clk,
  input logic         rst_n,
  input logic         busy,
  input logic         done,
  input logic [W-1:0] rx,
  input logic [W-1:0] ry,
  input logic [W-1:0] rz,
  input logic         inf_q,
  input logic         wr_en,
  input logic [W-1:0] wr_data,
  input logic         mul_start,
  input ridx_t        mul_sel_a,
  input ridx_t        mul_sel_b
);

  localparam logic [W-1:0] QW = W'(Q);

  a_r2_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r2_idle_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r2_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(busy));

  a_r5_out_range: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (rx < QW) && (ry < QW) && (rz < QW));

  a_r5_wr_range: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_data < QW));

  a_r3_no_self_square: assert property (@(posedge clk) disable iff (!rst_n)
    mul_start |-> (mul_sel_a != mul_sel_b));

  a_r6_inf_override: assert property (@(posedge clk) disable iff (!rst_n)
    (done && inf_q) |-> (rx == W'(1)) && (ry == W'(1)) && (rz == '0));

  a_r8_flag_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(inf_q));

  a_r7_mul_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mul_start |-> busy);

endmodule

bind jdbl_core jdbl_core_chk #(.W(W), .Q(Q)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
  .rx(rx), .ry(ry), .rz(rz), .inf_q(inf_q),
  .wr_en(wr_en), .wr_data(wr_data), .mul_start(mul_start),
  .mul_sel_a(mul_sel_a), .mul_sel_b(mul_sel_b)
);

// File: tb/jdbl_core_tb.sv
module jdbl_core_tb;

  localparam int W = 8;
  localparam int Q = 251;
  localparam int LIMIT = 2000;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [W-1:0] px = '0, py = '0, pz = '0;
  logic         busy, done;
  logic [W-1:0] rx, ry, rz;

  int n_chk = 0;
  int n_bad = 0;
  int ref_lat = -1;

  always #2 clk = ~clk;

  jdbl_core #(.W(W), .Q(Q)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .px(px), .py(py), .pz(pz),
    .busy(busy), .done(done), .rx(rx), .ry(ry), .rz(rz)
  );

  function automatic int fm(input int a, input int b);
    return ((a % Q) * (b % Q)) % Q;
  endfunction

  function automatic int fs(input int a, input int b);
    return ((a - b) % Q + Q) % Q;
  endfunction

  function automatic int finv(input int a);
    int r = 1;
    int base = a % Q;
    int e = Q - 2;
    while (e > 0) begin
      if (e % 2 == 1) r = fm(r, base);
      base = fm(base, base);
      e = e / 2;
    end
    return r;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // drive one start pulse, return cycles until done (or -1 on timeout)
  task automatic run_op(input int x, input int y, input int z, output int lat);
    @(negedge clk);
    px = W'(x); py = W'(y); pz = W'(z); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R2 busy after start", int'(busy), 1);
    lat = 1;
    while (!done && lat < LIMIT) begin
      @(negedge clk);
      lat++;
    end
    if (!done) begin
      check("R2 watchdog: done never seen", 0, 1);
      lat = -1;
    end else begin
      check("R2 busy low in done cycle", int'(busy), 0);
    end
  endtask

  task automatic check_latency(input int lat);
    if (ref_lat < 0) ref_lat = lat;
    else check("R7 constant latency", lat, ref_lat);
  endtask

  task automatic t_reset();
    check("R1 busy at reset", int'(busy), 0);
    check("R1 done at reset", int'(done), 0);
    check("R1 outputs at reset", int'(rx) + int'(ry) + int'(rz), 0);
  endtask

  // finite point (x,y) affine, scaled by z
  task automatic t_double(input int x, input int y, input int z);
    int jx, jy, lat, lam, x3, y3, zi, ax, ay;
    jx = fm(x, fm(z, z));
    jy = fm(y, fm(z, fm(z, z)));
    run_op(jx, jy, z, lat);
    check_latency(lat);
    check("R4 rz = 2YZ", int'(rz), fm(2, fm(jy, z)));
    check("R5 range", int'(rx < Q && ry < Q && rz < Q), 1);
    lam = fm(fs(fm(3, fm(x, x)), 3), finv(fm(2, y)));
    x3  = fs(fm(lam, lam), fm(2, x));
    y3  = fs(fm(lam, fs(x, x3)), y);
    zi  = finv(int'(rz));
    ax  = fm(int'(rx), fm(zi, zi));
    ay  = fm(int'(ry), fm(zi, fm(zi, zi)));
    check("R3 affine x", ax, x3);
    check("R3 affine y", ay, y3);
    @(negedge clk);
    check("R2 single done pulse", int'(done), 0);
    check("R2 outputs held", int'(rz), fm(2, fm(jy, z)));
  endtask

  task automatic t_infinity(input int x, input int y);
    int lat;
    run_op(x, y, 0, lat);
    check_latency(lat);
    check("R6 inf rx", int'(rx), 1);
    check("R6 inf ry", int'(ry), 1);
    check("R6 inf rz", int'(rz), 0);
  endtask

  task automatic t_order_two(input int x, input int z);
    int lat;
    run_op(fm(x, fm(z, z)), 0, z, lat);
    check_latency(lat);
    check("R9 order-two rz", int'(rz), 0);
  endtask

  task automatic t_busy_start();
    int jx, jy, z, cyc;
    z  = 7;
    jx = fm(9, fm(z, z));
    jy = fm(4, fm(z, fm(z, z)));
    @(negedge clk);
    px = W'(jx); py = W'(jy); pz = W'(z); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    px = 8'd33; py = 8'd44; pz = 8'd0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (!done && cyc < LIMIT) begin
      @(negedge clk);
      cyc++;
    end
    check("R8 done seen", int'(done), 1);
    check("R8 first point kept", int'(rz), fm(2, fm(jy, z)));
    repeat (4) begin
      @(negedge clk);
      check("R8 no second done", int'(done), 0);
    end
    check("R8 idle after run", int'(busy), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_double(5, 7, 1);
    t_double(100, 200, 3);
    t_double(250, 1, 250);
    t_double(17, 250, 99);
    t_double(0, 5, 2);
    t_infinity(123, 45);
    t_infinity(0, 0);
    t_infinity(250, 250);
    t_order_two(12, 5);
    t_busy_start();
    t_double(77, 88, 200);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #400000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule